// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block carries one byte per frame over a serial Monitor channel, in both directions. The transmit side signals each byte with an active-low MX bit. The receive side confirms each byte with an active-low MR bit. Frame timing arrives as a single-cycle `frame_stb`. When the strobe is high, the incoming byte and the incoming MX and MR bits are already parallel and valid. The outgoing byte and handshake bits are held steady between strobes so that a serializer can pick them up.

Software reaches four registers over a small register bus: the transmit byte, the received byte, a 4-bit control word and a 4-bit status word that clears when read. Each handshake bit can be pinned at its idle value of 1, or it can be handed to the protocol engine. A single interrupt line combines the status bits that the control word enables.

A byte is accepted only when two consecutive frames carry it with MX low. A packet ends after two consecutive frames with MX high. On the sending side, a byte that gets no acknowledge is abandoned. This happens after a two-frame grace period followed by two further frames with MR high.

Top module: `mon_hs_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, `tx_mx` and `tx_mr` are 1, and `irq` is 0.
- R2: The register addresses are: 0 transmit byte (read/write), 1 received byte (read only), 2 control, 3 status. Control bits: 3 receive-interrupt enable, 2 MR control, 1 transmit-interrupt enable, 0 MX control. Status bits: 3 byte received, 2 end of packet, 1 acknowledged, 0 abort. Bits 7..4 of control and status read as 0.
- R3: Reading status returns its current value and clears it in the same cycle. A status event that arrives in that same cycle is kept.
- R4: With MR control 0, `tx_mr` stays 1. The byte-received status is set only for the first byte accepted after reset or after an end of packet.
- R5: With MR control 1, `tx_mr` goes to 0 at the strobe that accepts a byte and returns to 1 at the next strobe. The byte-received status is set for every accepted byte.
- R6: With MX control 0, `tx_mx` stays 1, and writing the transmit byte starts no transfer, so no acknowledged or abort status is set.
- R7: `irq` is 1 exactly when a set status bit is enabled. Bits 3 and 2 are enabled by receive-interrupt enable, and bits 1 and 0 by transmit-interrupt enable. Enabling a bit that is already set raises `irq` at once.
- R8: A byte is accepted when two consecutive strobes show it with `rx_mx` 0, and the first of these follows a strobe with `rx_mx` 1. The received byte register then takes that value. If the two values differ, nothing is accepted and `tx_mr` stays 1.
- R9: After a strobe with `rx_mx` falling, two consecutive strobes with `rx_mx` 1 set end-of-packet status. A single high strobe does not.
- R10: With MX control 1 and no transfer running, writing the transmit byte drives `tx_mx` to 0 from the next cycle on, with `tx_byte` showing the written value. The first strobe that shows `rx_mr` 0 sets acknowledged status and returns `tx_mx` to 1.
- R11: While a transfer runs, the first two strobes are a grace period. After that, two further strobes with `rx_mr` 1 set abort status at the second of them and return `tx_mx` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle frame strobe; the incoming byte and bits are valid while it is high |
| rx_byte | input | 8 | Incoming Monitor byte |
| rx_mx | input | 1 | Incoming MX bit, active low |
| rx_mr | input | 1 | Incoming MR bit, active low |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| tx_byte | output | 8 | Outgoing Monitor byte (the transmit register) |
| tx_mx | output | 1 | Outgoing MX bit, active low |
| tx_mr | output | 1 | Outgoing MR bit, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every protocol result is registered at the clock edge that carries the strobe or the bus write: status bits, the received byte, `tx_mr` and `tx_mx` all change one edge after their cause. `irq` follows the status and control registers with no added delay. Read data is combinational and is valid in the cycle of the request, and the clear that a status read causes shows up one edge later. The bench applies every stimulus at a falling edge and compares pins at the next falling edge. It compares read data a nanosecond after the request is placed, well before the rising edge that would clear it.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
  typedef enum logic [1:0] {
    ADR_TXD  = 2'd0,
    ADR_RXD  = 2'd1,
    ADR_CTRL = 2'd2,
    ADR_STAT = 2'd3
  } mon_addr_e;

  // Status bit positions
  localparam int ST_RDR = 3;
  localparam int ST_EOP = 2;
  localparam int ST_ACK = 1;
  localparam int ST_ABT = 0;
  // Control bit positions
  localparam int CT_RIE = 3;
  localparam int CT_MRC = 2;
  localparam int CT_XIE = 1;
  localparam int CT_MXC = 0;

  // Per-status-bit enable mask derived from the control word
  function automatic logic [3:0] mon_irq_mask(input logic [3:0] ctrl);
    return {ctrl[CT_RIE], ctrl[CT_RIE], ctrl[CT_XIE], ctrl[CT_XIE]};
  endfunction

  // Whether an accepted byte may flag byte-received status
  function automatic logic mon_rdr_allowed(input logic mr_ctrl, input logic first_of_pkt);
    return mr_ctrl | first_of_pkt;
  endfunction
endpackage

// File: rtl/mon_rx.sv
module mon_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_mx,
  input  logic          mr_ctrl,
  output logic [DW-1:0] rx_data,
  output logic          mr_q,
  output logic          ev_rdr,
  output logic          ev_eop
);
  import mon_hs_pkg::*;

  logic          prev_mx;
  logic          have_cand;
  logic          active;
  logic          first_q;
  logic [DW-1:0] cand;
  logic          mx_fall;
  logic          accept;

  assign mx_fall = frame_stb & ~rx_mx & prev_mx;
  assign accept  = frame_stb & ~rx_mx & ~prev_mx & have_cand & (cand == rx_byte);
  assign ev_rdr  = accept & mon_rdr_allowed(mr_ctrl, first_q);
  assign ev_eop  = frame_stb & rx_mx & prev_mx & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mx   <= 1'b1;
      have_cand <= 1'b0;
      active    <= 1'b0;
      first_q   <= 1'b1;
      cand      <= '0;
      rx_data   <= '0;
      mr_q      <= 1'b1;
    end else if (frame_stb) begin
      prev_mx <= rx_mx;
      mr_q    <= 1'b1;
      if (mx_fall) begin
        cand      <= rx_byte;
        have_cand <= 1'b1;
        active    <= 1'b1;
      end else if (!rx_mx) begin
        have_cand <= 1'b0;
        if (accept) begin
          rx_data <= rx_byte;
          mr_q    <= 1'b0;
          first_q <= 1'b0;
        end
      end else begin
        have_cand <= 1'b0;
        if (ev_eop) begin
          active  <= 1'b0;
          first_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mon_tx.sv
module mon_tx #(
  parameter int GRACE     = 2,
  parameter int ABORT_RUN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic rx_mr,
  input  logic start,
  output logic busy,
  output logic ev_ack,
  output logic ev_abort
);
  localparam int NW = $clog2(GRACE + 1);
  localparam int MW = $clog2(ABORT_RUN + 1);

  logic [NW-1:0] nfr;
  logic [MW-1:0] miss;
  logic          in_window;

  assign in_window = (nfr == NW'(GRACE));
  assign ev_ack    = busy & frame_stb & ~rx_mr;
  assign ev_abort  = busy & frame_stb & rx_mr & in_window & (miss == MW'(ABORT_RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      nfr  <= '0;
      miss <= '0;
    end else if (start) begin
      busy <= 1'b1;
      nfr  <= '0;
      miss <= '0;
    end else if (busy && frame_stb) begin
      if (ev_ack || ev_abort) begin
        busy <= 1'b0;
      end else if (in_window) begin
        miss <= miss + 1'b1;
      end else begin
        nfr <= nfr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mon_regs.sv
module mon_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] rx_data,
  input  logic [3:0]    ev_set,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] txd,
  output logic [3:0]    ctrl,
  output logic [3:0]    stat,
  output logic          txd_wr,
  output logic          rd_stat,
  output logic          irq
);
  import mon_hs_pkg::*;

  logic wr_en;

  assign wr_en   = bus_sel & bus_wr;
  assign txd_wr  = wr_en & (bus_addr == ADR_TXD);
  assign rd_stat = bus_sel & ~bus_wr & (bus_addr == ADR_STAT);
  assign irq     = |(stat & mon_irq_mask(ctrl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd  <= '0;
      ctrl <= '0;
      stat <= '0;
    end else begin
      if (txd_wr) txd <= bus_wdata;
      if (wr_en && bus_addr == ADR_CTRL) ctrl <= bus_wdata[3:0];
      stat <= (rd_stat ? 4'b0 : stat) | ev_set;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADR_TXD:  bus_rdata = txd;
      ADR_RXD:  bus_rdata = rx_data;
      ADR_CTRL: bus_rdata = {{(DW-4){1'b0}}, ctrl};
      default:  bus_rdata = {{(DW-4){1'b0}}, stat};
    endcase
  end
endmodule

// File: rtl/mon_hs_ctrl.sv
module mon_hs_ctrl #(
  parameter int DW        = 8,
  parameter int GRACE     = 2,
  parameter int ABORT_RUN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_mx,
  input  logic          rx_mr,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] tx_byte,
  output logic          tx_mx,
  output logic          tx_mr
  ,output logic         irq
);
  import mon_hs_pkg::*;

  logic [DW-1:0] rx_data;
  logic [3:0]    ctrl_q;
  logic [3:0]    stat_q;
  logic [3:0]    ev_set;
  logic          txd_wr, rd_stat;
  logic          mr_q, ev_rdr, ev_eop;
  logic          tx_busy, ev_ack, ev_abort, tx_start;

  assign tx_start = txd_wr & ~tx_busy & ctrl_q[CT_MXC];
  assign ev_set   = {ev_rdr, ev_eop, ev_ack, ev_abort};
  assign tx_mx    = ~(ctrl_q[CT_MXC] & tx_busy);
  assign tx_mr    = ctrl_q[CT_MRC] ? mr_q : 1'b1;

  mon_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_data(rx_data),
    .ev_set(ev_set), .bus_rdata(bus_rdata), .txd(tx_byte), .ctrl(ctrl_q),
    .stat(stat_q), .txd_wr(txd_wr), .rd_stat(rd_stat), .irq(irq)
  );

  mon_rx #(.DW(DW)) rx_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_byte(rx_byte),
    .rx_mx(rx_mx), .mr_ctrl(ctrl_q[CT_MRC]), .rx_data(rx_data),
    .mr_q(mr_q), .ev_rdr(ev_rdr), .ev_eop(ev_eop)
  );

  mon_tx #(.GRACE(GRACE), .ABORT_RUN(ABORT_RUN)) tx_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_mr(rx_mr),
    .start(tx_start), .busy(tx_busy), .ev_ack(ev_ack), .ev_abort(ev_abort)
  );
endmodule

// File: rtl/mon_hs_chk.sv
module mon_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ctrl,
  input logic [3:0] stat,
  input logic [3:0] ev_set,
  input logic       rd_stat,
  input logic       ev_ack,
  input logic       ev_abort,
  input logic       tx_mx,
  input logic       tx_mr,
  input logic       irq
);
  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ev_set == 4'b0) |=> (stat == 4'b0));

  p_event_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[3] |=> stat[3]);

  p_mr_pinned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] |-> tx_mr);

  p_mx_pinned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> tx_mx);

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[3] && !ctrl[1]) |-> !irq);

  p_ack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> tx_mx);

  p_abort_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (tx_mx && stat[0]));
endmodule

bind mon_hs_ctrl mon_hs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .stat(stat_q), .ev_set(ev_set),
  .rd_stat(rd_stat), .ev_ack(ev_ack), .ev_abort(ev_abort),
  .tx_mx(tx_mx), .tx_mr(tx_mr), .irq(irq)
);

// File: tb/mon_hs_ctrl_tb_top.sv
module mon_hs_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_mx = 1'b1;
  logic       rx_mr = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, tx_byte;
  logic       tx_mx, tx_mr, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string req; } exp_t;
  exp_t sb_q[$];
  event rd_ev;

  always #4 clk = ~clk;

  mon_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_byte(rx_byte),
    .rx_mx(rx_mx), .rx_mr(rx_mr), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_mx(tx_mx), .tx_mr(tx_mr), .irq(irq)
  );

  // Monitor: pops expected read data and compares with the bus
  initial forever begin
    @(rd_ev);
    #0;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e.exp) begin
        n_bad++;
        $display("FAIL %s read: actual %02h expected %02h", e.req, bus_rdata, e.exp);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pin: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    sb_q.push_back('{exp: exp, req: req});
    -> rd_ev;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic frame(input logic mx, input logic mr, input logic [7:0] b);
    @(negedge clk);
    frame_stb = 1'b1; rx_mx = mx; rx_mr = mr; rx_byte = b;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {7'b0, tx_mx}, 8'h01);
    chk("R1", {7'b0, tx_mr}, 8'h01);
    chk("R1", {7'b0, irq}, 8'h00);
    reg_rd(2'd3, 8'h00, "R1");
    reg_rd(2'd2, 8'h00, "R1");
    reg_rd(2'd1, 8'h00, "R1");
    reg_rd(2'd0, 8'h00, "R1");
    // R2 control map, upper bits read as zero
    reg_wr(2'd2, 8'hFF);
    reg_rd(2'd2, 8'h0F, "R2");
    reg_wr(2'd0, 8'h5E);
    reg_rd(2'd0, 8'h5E, "R2");
    // MX control was on: that write started a send; let the remote ack it
    frame(1'b1, 1'b0, 8'h00);
    reg_rd(2'd3, 8'h02, "R10");
    reg_wr(2'd2, 8'h0F);

    // R5 / R8: receive with MR under protocol control
    frame(1'b0, 1'b1, 8'hA5);
    chk("R5", {7'b0, tx_mr}, 8'h01);
    frame(1'b0, 1'b1, 8'hA5);
    chk("R5", {7'b0, tx_mr}, 8'h00);
    chk("R7", {7'b0, irq}, 8'h01);
    reg_rd(2'd1, 8'hA5, "R8");
    reg_rd(2'd3, 8'h08, "R5");
    reg_rd(2'd3, 8'h00, "R3");
    frame(1'b1, 1'b1, 8'h00);
    chk("R5", {7'b0, tx_mr}, 8'h01);
    frame(1'b0, 1'b1, 8'h3C);
    frame(1'b0, 1'b1, 8'h3C);
    reg_rd(2'd3, 8'h08, "R5");
    frame(1'b1, 1'b1, 8'h00);
    reg_rd(2'd3, 8'h00, "R9");
    frame(1'b1, 1'b1, 8'h00);
    reg_rd(2'd3, 8'h04, "R9");

    // R8 mismatch: no accept
    frame(1'b0, 1'b1, 8'h11);
    frame(1'b0, 1'b1, 8'h22);
    chk("R8", {7'b0, tx_mr}, 8'h01);
    reg_rd(2'd1, 8'h3C, "R8");
    reg_rd(2'd3, 8'h00, "R8");
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    reg_rd(2'd3, 8'h04, "R9");

    // R4: MR pinned, byte-received only for first byte of a packet
    reg_wr(2'd2, 8'h0B);
    frame(1'b0, 1'b1, 8'h55);
    frame(1'b0, 1'b1, 8'h55);
    chk("R4", {7'b0, tx_mr}, 8'h01);
    reg_rd(2'd3, 8'h08, "R4");
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b0, 1'b1, 8'h66);
    frame(1'b0, 1'b1, 8'h66);
    reg_rd(2'd3, 8'h00, "R4");
    reg_rd(2'd1, 8'h66, "R4");
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    reg_rd(2'd3, 8'h04, "R9");
    frame(1'b0, 1'b1, 8'h77);
    frame(1'b0, 1'b1, 8'h77);
    reg_rd(2'd3, 8'h08, "R4");
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    reg_rd(2'd3, 8'h04, "R9");

    // R7: masking and late enable
    reg_wr(2'd2, 8'h06);
    frame(1'b0, 1'b1, 8'hAA);
    frame(1'b0, 1'b1, 8'hAA);
    chk("R7", {7'b0, irq}, 8'h00);
    reg_wr(2'd2, 8'h0E);
    chk("R7", {7'b0, irq}, 8'h01);
    reg_rd(2'd3, 8'h08, "R7");
    chk("R7", {7'b0, irq}, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    reg_rd(2'd3, 8'h04, "R9");

    // R10: transmit and acknowledge
    reg_wr(2'd2, 8'h0F);
    reg_wr(2'd0, 8'h9A);
    chk("R10", {7'b0, tx_mx}, 8'h00);
    chk("R10", tx_byte, 8'h9A);
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    chk("R10", {7'b0, tx_mx}, 8'h00);
    frame(1'b1, 1'b0, 8'h00);
    chk("R10", {7'b0, tx_mx}, 8'h01);
    chk("R10", {7'b0, irq}, 8'h01);
    reg_rd(2'd3, 8'h02, "R10");

    // R11: abort after grace plus two unacknowledged frames
    reg_wr(2'd0, 8'h44);
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    chk("R11", {7'b0, tx_mx}, 8'h00);
    reg_rd(2'd3, 8'h00, "R11");
    frame(1'b1, 1'b1, 8'h00);
    chk("R11", {7'b0, tx_mx}, 8'h01);
    reg_rd(2'd3, 8'h01, "R11");

    // R6: MX pinned, write starts nothing
    reg_wr(2'd2, 8'h0E);
    reg_wr(2'd0, 8'h12);
    chk("R6", {7'b0, tx_mx}, 8'h01);
    frame(1'b1, 1'b0, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    chk("R6", {7'b0, tx_mx}, 8'h01);
    reg_rd(2'd3, 8'h00, "R6");

    // R3: event in the same cycle as a clearing read is kept
    reg_wr(2'd2, 8'h0F);
    frame(1'b0, 1'b1, 8'h81);
    @(negedge clk);
    frame_stb = 1'b1; rx_mx = 1'b0; rx_mr = 1'b1; rx_byte = 8'h81;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd3;
    #1;
    sb_q.push_back('{exp: 8'h00, req: "R3"});
    -> rd_ev;
    @(negedge clk);
    frame_stb = 1'b0; bus_sel = 1'b0;
    reg_rd(2'd3, 8'h08, "R3");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule